// File: doc/BRIEF.md
# Watchdog Timer with Low-Power Modes

This block is a system watchdog built around a down-counter that must be serviced by software. Any write to its single memory-mapped control register restarts the count from all ones. If software stops writing, the counter eventually passes zero and the block emits a one-cycle watchdog reset pulse, then starts counting again from all ones. The counter takes one step per enable pulse from a chosen count source. Two prescaled one-cycle enables enter the block, and a bit of the control register chooses between them.

The counter keeps running while the core waits for an interrupt. It also runs through the oscillator-settling interval after stop mode ends. It holds its value only while the core reports that it is in stop mode. A second register bit decides what a stop request does: it either asks the core to enter stop mode or raises an internal reset pulse. That bit accepts one write after reset and is locked from then on. Reading the register returns the two option bits and the lock flag.

Top module: `wdt_lp_top`

## Requirements
- R1: After reset the readback is 0x00, the outputs wdtRst, stopEnter and intRst are low, and the counter holds all ones.
- R2: A write with wrAddr equal to REG_ADDR (default 0x39) reloads the counter to all ones. A write to any other address changes neither the counter nor the register.
- R3: Register bit 7 picks the count source: 0 selects tickSlow and 1 selects tickFast. The enable that is not selected has no effect on the counter.
- R4: While coreStop is high the counter holds its value, and selected ticks are ignored.
- R5: While coreStop is low the counter decrements on every selected tick. This covers wait mode and the oscillator-settling interval after stop mode.
- R6: The 2^CNT_W-th selected tick after a reload finds the counter at zero. wdtRst is then high for exactly the one following cycle, and the counter reloads to all ones.
- R7: Register bit 6 takes its value from the first register write after reset, and that write sets the lock flag in bit 5. Later writes leave bit 6 unchanged but still update bit 7 and still reload the counter.
- R8: In the cycle after a stopReq pulse, the block drives stopEnter high for one cycle when bit 6 is 0, or intRst high for one cycle when bit 6 is 1. It never drives both.
- R9: A register write in the same cycle as a selected tick reloads the counter, and that tick is not counted.
- R10: The readback is {bit7 source select, bit6 stop function, bit5 lock flag, 5'b00000}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 8 | Write data |
| tickSlow | input | 1 | One-cycle enable, slower source |
| tickFast | input | 1 | One-cycle enable, faster source |
| coreStop | input | 1 | High while the core is in stop mode |
| stopReq | input | 1 | One-cycle stop instruction request |
| rdData | output | 8 | Register readback |
| wdtRst | output | 1 | One-cycle watchdog reset pulse |
| stopEnter | output | 1 | One-cycle request to enter stop mode |
| intRst | output | 1 | One-cycle internal reset from a stop request |

## Verification
The bench uses a 4-bit counter and sweeps every reload point. It confirms that every write restarts the full 16-tick count, so a design that ignored writes part-way through would fire early. It also checks a write that lands in the same cycle as a tick, which a design with the wrong priority would count one short. It confirms that stop-mode ticks are dropped and that counting resumes afterwards, and that the unselected enable has no effect; either mistake moves the underflow. Finally it writes bit 6 twice in each direction across two resets, so a lock that failed to engage would flip the stop decision from stop entry to internal reset.

// File: rtl/wdt_lp_pkg.sv
package wdt_lp_pkg;
  // register bit positions
  localparam int SRC_BIT  = 7;
  localparam int STFN_BIT = 6;
  localparam int LOCK_BIT = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic reload;
    logic dec;
  } wdt_strobe_t;
endpackage

// File: rtl/wdt_lp_ctrl.sv
module wdt_lp_ctrl
  import wdt_lp_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int REG_ADDR = 'h39
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              tickSlow,
  input  logic              tickFast,
  input  logic              coreStop,
  input  logic              stopReq,
  output wdt_strobe_t       strobe,
  output logic [7:0]        rdData,
  output logic              stopEnter,
  output logic              intRst
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

  logic srcSel, stopFn, lockFlag;
  logic wrHit, selTick;
  logic unusedLowBits;

  assign unusedLowBits = ^wrData[4:0];
  assign wrHit   = wrEn && (wrAddr == HIT_ADDR);
  assign selTick = srcSel ? tickFast : tickSlow;

  always_comb begin
    strobe.reload = wrHit;
    strobe.dec    = selTick && !coreStop && !wrHit;
  end

  // control register with write-once stop function bit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcSel   <= 1'b0;
      stopFn   <= 1'b0;
      lockFlag <= 1'b0;
    end else if (wrHit) begin
      srcSel <= wrData[SRC_BIT];
      if (!lockFlag) begin
        stopFn   <= wrData[STFN_BIT];
        lockFlag <= 1'b1;
      end
    end
  end

  // stop request decision
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopEnter <= 1'b0;
      intRst    <= 1'b0;
    end else begin
      stopEnter <= stopReq && !stopFn;
      intRst    <= stopReq && stopFn;
    end
  end

  always_comb begin
    rdData           = 8'h00;
    rdData[SRC_BIT]  = srcSel;
    rdData[STFN_BIT] = stopFn;
    rdData[LOCK_BIT] = lockFlag;
  end

  // R7: once locked, bit 6 never changes
  p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    lockFlag |=> (stopFn == $past(stopFn)));
  // R7: any register write leaves the lock set
  p_lock_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrHit |=> lockFlag);
  // R8: the two stop outcomes are exclusive
  p_stop_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(stopEnter && intRst));
  // R4: no count while in stop mode
  p_freeze_r4: assert property (@(posedge clk) disable iff (!rstN)
    coreStop |-> !strobe.dec);
endmodule

// File: rtl/wdt_lp_datapath.sv
module wdt_lp_datapath
  import wdt_lp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  wdt_strobe_t strobe,
  output logic        wdtRst
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic             atZero;

  assign atZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= CNT_TOP;
      wdtRst <= 1'b0;
    end else begin
      wdtRst <= 1'b0;
      if (strobe.reload) begin
        cnt <= CNT_TOP;
      end else if (strobe.dec) begin
        if (atZero) begin
          cnt    <= CNT_TOP;
          wdtRst <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R2: a reload restores all ones
  p_reload_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> (cnt == CNT_TOP));
  // R4: counter holds without a strobe
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.reload && !strobe.dec) |=> $stable(cnt));
  // R5: one step per selected tick
  p_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dec && !strobe.reload && !atZero) |=> (cnt == $past(cnt) - 1'b1));
  // R6: reset pulse lasts one cycle
  p_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    wdtRst |=> !wdtRst);
endmodule

// File: rtl/wdt_lp_top.sv
module wdt_lp_top
  import wdt_lp_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 8,
  parameter int REG_ADDR = 'h39
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              tickSlow,
  input  logic              tickFast,
  input  logic              coreStop,
  input  logic              stopReq,
  output logic [7:0]        rdData,
  output logic              wdtRst,
  output logic              stopEnter,
  output logic              intRst
);
  wdt_strobe_t strobe;

  wdt_lp_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tickSlow(tickSlow), .tickFast(tickFast), .coreStop(coreStop),
    .stopReq(stopReq), .strobe(strobe), .rdData(rdData),
    .stopEnter(stopEnter), .intRst(intRst)
  );

  wdt_lp_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wdtRst(wdtRst)
  );
endmodule

// File: tb/wdt_lp_top_tb_top.sv
`timescale 1ns/1ps
module wdt_lp_top_tb_top;
  localparam int CW   = 4;
  localparam int FULL = 1 << CW;
  localparam logic [7:0] RA = 8'h39;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, tickSlow = 1'b0, tickFast = 1'b0;
  logic coreStop = 1'b0, stopReq = 1'b0;
  logic [7:0] wrAddr = '0, wrData = '0, rdData;
  logic wdtRst, stopEnter, intRst;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_lp_top #(.CNT_W(CW), .ADDR_W(8), .REG_ADDR('h39)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tickSlow(tickSlow), .tickFast(tickFast), .coreStop(coreStop),
    .stopReq(stopReq), .rdData(rdData), .wdtRst(wdtRst),
    .stopEnter(stopEnter), .intRst(intRst)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [7:0] d, input bit fast = 0);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d; tickFast = fast;
    @(negedge clk); wrEn = 1'b0; tickFast = 1'b0;
  endtask

  // one tick, then the cycle in which a resulting pulse is visible
  task automatic tick(input bit fast, input bit slow, output bit pulse);
    @(negedge clk); tickFast = fast; tickSlow = slow;
    @(negedge clk); tickFast = 1'b0; tickSlow = 1'b0;
    pulse = wdtRst;
  endtask

  task automatic ticks(input int n, input bit fast);
    bit p;
    for (int i = 0; i < n; i++) tick(fast, !fast, p);
  endtask

  task automatic countToPulse(input bit fast, output int n);
    bit p;
    n = 0;
    p = 1'b0;
    while (!p && n < 100) begin
      tick(fast, !fast, p);
      n++;
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int n;
    bit p;
    doReset();
    // R1 reset state
    check("R1 rdData", rdData, 0);
    check("R1 wdtRst", wdtRst, 0);
    check("R1 stopEnter", stopEnter, 0);
    check("R1 intRst", intRst, 0);
    countToPulse(1'b0, n);
    check("R1 counter starts all ones", n, FULL);

    // R7/R10: first write 0x80 locks bit 6 at 0
    regWrite(RA, 8'h80);
    check("R10 readback after 0x80", rdData, 'hA0);
    // R6 underflow with fast source, pulse lasts one cycle
    countToPulse(1'b1, n);
    check("R6 ticks to underflow", n, FULL);
    @(negedge clk);
    check("R6 pulse one cycle", wdtRst, 0);
    countToPulse(1'b1, n);
    check("R6 reload after underflow", n, FULL);

    // R3 slow ignored when fast selected
    regWrite(RA, 8'h80);
    ticks(10, 1'b0);
    countToPulse(1'b1, n);
    check("R3 slow ignored with bit7=1", n, FULL);

    // R2 sweep of reload point and foreign-address writes
    for (int k = 0; k < FULL; k++) begin
      regWrite(RA, 8'h80);
      ticks(k, 1'b1);
      regWrite(RA, 8'h80);
      countToPulse(1'b1, n);
      check("R2 write reloads", n, FULL);
      regWrite(RA, 8'h80);
      ticks(k, 1'b1);
      regWrite(8'h3A, 8'h00);
      countToPulse(1'b1, n);
      check("R2 other address ignored", n, FULL - k);
    end
    check("R2 register untouched", rdData, 'hA0);

    // R4/R5 freeze in stop, resume after
    regWrite(RA, 8'h80);
    ticks(5, 1'b1);
    coreStop = 1'b1;
    ticks(7, 1'b1);
    coreStop = 1'b0;
    countToPulse(1'b1, n);
    check("R4 R5 freeze then resume", n, FULL - 5);

    // R9 write wins over simultaneous tick
    regWrite(RA, 8'h80);
    ticks(3, 1'b1);
    regWrite(RA, 8'h80, 1'b1);
    countToPulse(1'b1, n);
    check("R9 write beats tick", n, FULL);

    // R7 later write cannot set bit 6; bit 7 still writable
    regWrite(RA, 8'h40);
    check("R7 bit6 locked at 0", rdData, 'h20);
    // R3 slow source now
    ticks(4, 1'b1);
    countToPulse(1'b0, n);
    check("R3 slow source, fast ignored", n, FULL);
    // R8 stop entry
    @(negedge clk); stopReq = 1'b1;
    @(negedge clk); stopReq = 1'b0;
    check("R8 stopEnter", stopEnter, 1);
    check("R8 no intRst", intRst, 0);
    @(negedge clk);
    check("R8 stopEnter one cycle", stopEnter, 0);

    // second reset: lock bit 6 at 1
    doReset();
    check("R1 rdData after reset", rdData, 0);
    regWrite(RA, 8'h40);
    check("R7 first write sets bit6", rdData, 'h60);
    regWrite(RA, 8'h80);
    check("R7 bit6 stays 1, bit7 written", rdData, 'hE0);
    @(negedge clk); stopReq = 1'b1;
    @(negedge clk); stopReq = 1'b0;
    check("R8 intRst", intRst, 1);
    check("R8 no stopEnter", stopEnter, 0);
    @(negedge clk);
    check("R8 intRst one cycle", intRst, 0);
    tick(1'b0, 1'b1, p);
    check("R6 no early pulse", p, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule